// File: doc/BRIEF.md
# Integer Execution Unit with Immediate Widening

This block is the combinational integer execution unit of a small three-format RISC pipeline. It takes two register operands, the raw 16-bit immediate field of the instruction and an already decoded operation code, and returns a full-width result together with a raw signed-overflow flag. The immediate is widened inside the unit, and the widening rule depends on the operation class. Logical immediates are padded with zeros. Arithmetic and compare immediates repeat their sign bit, and this also holds for the unsigned add-immediate form. The upper-load form moves the field into the high half of the word.

The caller decodes the instruction and reads the register file. It presents both register values, the immediate field and the 5-bit operation code. In the same cycle it takes the result and the overflow flag. The overflow flag only reports the condition. Any trap on it is handled outside the block. A full-width constant is built from two operations: an upper-load of the high half, then an OR-immediate of the low half applied to that value.

Top module: `int_alu`

## Requirements
- R1: For ANDI (5'h0C), ORI (5'h0D) and XORI (5'h0E), the immediate is zero-extended before the operation with opa_i, so the upper 16 result bits equal the same logic function of opa_i[31:16] with zero.
- R2: For ADDI (5'h0A), ADDIU (5'h0B), SLTI (5'h0F) and SLTIU (5'h10), the immediate is sign-extended to 32 bits. ADDI and ADDIU return opa_i plus that value, modulo 2^32.
- R3: ovf_o is 1 only for ADD (5'h00), SUB (5'h02) and ADDI (5'h0A). It stays 0 for every other code, including ADDU (5'h01), SUBU (5'h03) and ADDIU (5'h0B), whatever the operands.
- R4: For ADD and ADDI, ovf_o is 1 exactly when both addends have the same sign and the sum sign differs from it. For SUB, it is 1 exactly when the operand signs differ and the result sign differs from opa_i.
- R5: LUI (5'h11) returns imm_i in bits 31:16 and zero in bits 15:0, and ignores opa_i and opb_i.
- R6: SLT (5'h08) and SLTI (5'h0F) return 1 when opa_i is less than the second operand as signed two's complement numbers, and 0 otherwise. The result stays correct when the difference overflows, and bits 31:1 are zero.
- R7: SLTU (5'h09) and SLTIU (5'h10) compare as unsigned numbers. SLTIU compares against the sign-extended immediate. Bits 31:1 are zero.
- R8: Applying ORI with opa_i equal to a LUI result and the low half in imm_i yields the full 32-bit constant, with the upper half unchanged.
- R9: The register forms ADD, ADDU, SUB, SUBU (opa_i minus opb_i), AND (5'h04), OR (5'h05), XOR (5'h06) and NOR (5'h07) define all 32 result bits from the full 32-bit sources.
- R10: result_o and ovf_o are combinational and follow an input change within the same clock cycle.
- R11: Any code above 5'h11 returns a zero result and ovf_o equal to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa_i | input | 32 | First register operand |
| opb_i | input | 32 | Second register operand (unused by immediate forms) |
| imm_i | input | 16 | Raw immediate field of the instruction |
| op_i | input | 5 | Decoded operation code |
| result_o | output | 32 | Full-width result |
| ovf_o | output | 1 | Raw signed-overflow indication |

## Verification
The signed compare and the overflow detection both come from the same subtractor, so they are active together whenever a set-less-than sees operands whose difference wraps. The bench provokes this by comparing the most negative value against a small positive one, and the most positive value against minus one. It checks that the compare bit still reflects the true signed order and that ovf_o stays low, because a compare never reports overflow. Sign extension and overflow also meet in ADDI with a negative immediate on the most negative operand. The bench checks both the widened sum and the flag in that cycle.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;

   typedef enum logic [4:0] {
      OP_ADD   = 5'h00,
      OP_ADDU  = 5'h01,
      OP_SUB   = 5'h02,
      OP_SUBU  = 5'h03,
      OP_AND   = 5'h04,
      OP_OR    = 5'h05,
      OP_XOR   = 5'h06,
      OP_NOR   = 5'h07,
      OP_SLT   = 5'h08,
      OP_SLTU  = 5'h09,
      OP_ADDI  = 5'h0A,
      OP_ADDIU = 5'h0B,
      OP_ANDI  = 5'h0C,
      OP_ORI   = 5'h0D,
      OP_XORI  = 5'h0E,
      OP_SLTI  = 5'h0F,
      OP_SLTIU = 5'h10,
      OP_LUI   = 5'h11
   } alu_op_e;

   typedef enum logic [2:0] {
      SEL_ZERO,
      SEL_ARITH,
      SEL_LOGIC,
      SEL_SLTS,
      SEL_SLTU,
      SEL_PASSB
   } res_sel_e;

   typedef enum logic [1:0] {
      LFN_AND = 2'd0,
      LFN_OR  = 2'd1,
      LFN_XOR = 2'd2,
      LFN_NOR = 2'd3
   } lfn_e;

   typedef enum logic [1:0] {
      EXT_ZERO,
      EXT_SIGN,
      EXT_UPPER
   } ext_e;

   typedef struct packed {
      logic     use_imm;
      ext_e     ext;
      logic     sub;
      logic     trap;
      lfn_e     lfn;
      res_sel_e sel;
   } ctrl_t;

   function automatic ctrl_t decode_op(input logic [4:0] code);
      ctrl_t c;
      c.use_imm = 1'b0;
      c.ext     = EXT_SIGN;
      c.sub     = 1'b0;
      c.trap    = 1'b0;
      c.lfn     = LFN_AND;
      c.sel     = SEL_ZERO;
      case (code)
         OP_ADD:   begin c.sel = SEL_ARITH; c.trap = 1'b1; end
         OP_ADDU:  begin c.sel = SEL_ARITH; end
         OP_SUB:   begin c.sel = SEL_ARITH; c.sub = 1'b1; c.trap = 1'b1; end
         OP_SUBU:  begin c.sel = SEL_ARITH; c.sub = 1'b1; end
         OP_AND:   begin c.sel = SEL_LOGIC; c.lfn = LFN_AND; end
         OP_OR:    begin c.sel = SEL_LOGIC; c.lfn = LFN_OR; end
         OP_XOR:   begin c.sel = SEL_LOGIC; c.lfn = LFN_XOR; end
         OP_NOR:   begin c.sel = SEL_LOGIC; c.lfn = LFN_NOR; end
         OP_SLT:   begin c.sel = SEL_SLTS; c.sub = 1'b1; end
         OP_SLTU:  begin c.sel = SEL_SLTU; c.sub = 1'b1; end
         OP_ADDI:  begin c.sel = SEL_ARITH; c.use_imm = 1'b1; c.trap = 1'b1; end
         OP_ADDIU: begin c.sel = SEL_ARITH; c.use_imm = 1'b1; end
         OP_ANDI:  begin c.sel = SEL_LOGIC; c.use_imm = 1'b1; c.ext = EXT_ZERO; c.lfn = LFN_AND; end
         OP_ORI:   begin c.sel = SEL_LOGIC; c.use_imm = 1'b1; c.ext = EXT_ZERO; c.lfn = LFN_OR; end
         OP_XORI:  begin c.sel = SEL_LOGIC; c.use_imm = 1'b1; c.ext = EXT_ZERO; c.lfn = LFN_XOR; end
         OP_SLTI:  begin c.sel = SEL_SLTS; c.use_imm = 1'b1; c.sub = 1'b1; end
         OP_SLTIU: begin c.sel = SEL_SLTU; c.use_imm = 1'b1; c.sub = 1'b1; end
         OP_LUI:   begin c.sel = SEL_PASSB; c.use_imm = 1'b1; c.ext = EXT_UPPER; end
         default:  begin c.sel = SEL_ZERO; end
      endcase
      return c;
   endfunction

endpackage

// File: rtl/int_alu_imm_ext.sv
module int_alu_imm_ext
   import int_alu_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int IMM_W  = 16
) (
   input  logic [IMM_W-1:0]  imm_i,
   input  ext_e              mode_i,
   output logic [DATA_W-1:0] ext_o
);

   localparam int PAD_W = DATA_W - IMM_W;

   logic [DATA_W-1:0] zext;
   logic [DATA_W-1:0] sext;
   logic [DATA_W-1:0] upper;

   assign zext  = {{PAD_W{1'b0}}, imm_i};
   assign sext  = {{PAD_W{imm_i[IMM_W-1]}}, imm_i};
   assign upper = {imm_i, {PAD_W{1'b0}}};

   always_comb begin
      case (mode_i)
         EXT_ZERO:  ext_o = zext;
         EXT_UPPER: ext_o = upper;
         default:   ext_o = sext;
      endcase
   end

endmodule

// File: rtl/int_alu_addsub.sv
module int_alu_addsub #(
   parameter int DATA_W       = 32,
   parameter bit SLT_FROM_SUM = 1'b1
) (
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   input  logic              sub_i,
   output logic [DATA_W-1:0] sum_o,
   output logic              ovf_o,
   output logic              lt_s_o,
   output logic              lt_u_o
);

   localparam int MSB = DATA_W - 1;

   logic [DATA_W-1:0] b_eff;
   logic [DATA_W:0]   wide;
   logic              carry;

   assign b_eff = sub_i ? ~b_i : b_i;
   assign wide  = {1'b0, a_i} + {1'b0, b_eff} + {{DATA_W{1'b0}}, sub_i};
   assign sum_o = wide[MSB:0];
   assign carry = wide[DATA_W];

   // Signed wrap: the effective addends agree in sign, the sum does not.
   assign ovf_o = (a_i[MSB] == b_eff[MSB]) && (sum_o[MSB] != a_i[MSB]);

   // In subtract mode a missing carry-out is a borrow, so a < b unsigned.
   assign lt_u_o = ~carry;

   generate
      if (SLT_FROM_SUM) begin : g_slt_sum
         // Sign of the difference, corrected when the difference wrapped.
         assign lt_s_o = sum_o[MSB] ^ ovf_o;
      end else begin : g_slt_cmp
         assign lt_s_o = $signed(a_i) < $signed(b_i);
      end
   endgenerate

endmodule

// File: rtl/int_alu_logic.sv
module int_alu_logic
   import int_alu_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   input  lfn_e              fn_i,
   output logic [DATA_W-1:0] res_o
);

   always_comb begin
      case (fn_i)
         LFN_AND: res_o = a_i & b_i;
         LFN_OR:  res_o = a_i | b_i;
         LFN_XOR: res_o = a_i ^ b_i;
         default: res_o = ~(a_i | b_i);
      endcase
   end

endmodule

// File: rtl/int_alu.sv
module int_alu
   import int_alu_pkg::*;
#(
   parameter int DATA_W       = 32,
   parameter int IMM_W        = 16,
   parameter bit SLT_FROM_SUM = 1'b1
) (
   input  logic [DATA_W-1:0] opa_i,
   input  logic [DATA_W-1:0] opb_i,
   input  logic [IMM_W-1:0]  imm_i,
   input  logic [4:0]        op_i,
   output logic [DATA_W-1:0] result_o,
   output logic              ovf_o
);

   localparam int FLAG_PAD = DATA_W - 1;

   generate
      if (IMM_W < 1 || IMM_W >= DATA_W) begin : g_bad_imm_w
         $error("int_alu: IMM_W must lie between 1 and DATA_W-1");
      end
      if (DATA_W < 2) begin : g_bad_data_w
         $error("int_alu: DATA_W must be at least 2");
      end
   endgenerate

   ctrl_t             ctrl;
   logic [DATA_W-1:0] imm_wide;
   logic [DATA_W-1:0] src_b;
   logic [DATA_W-1:0] sum;
   logic              raw_ovf;
   logic              lt_s;
   logic              lt_u;
   logic [DATA_W-1:0] logic_res;

   assign ctrl = decode_op(op_i);

   int_alu_imm_ext #(
      .DATA_W (DATA_W),
      .IMM_W  (IMM_W)
   ) u_ext (
      .imm_i  (imm_i),
      .mode_i (ctrl.ext),
      .ext_o  (imm_wide)
   );

   assign src_b = ctrl.use_imm ? imm_wide : opb_i;

   int_alu_addsub #(
      .DATA_W       (DATA_W),
      .SLT_FROM_SUM (SLT_FROM_SUM)
   ) u_addsub (
      .a_i    (opa_i),
      .b_i    (src_b),
      .sub_i  (ctrl.sub),
      .sum_o  (sum),
      .ovf_o  (raw_ovf),
      .lt_s_o (lt_s),
      .lt_u_o (lt_u)
   );

   int_alu_logic #(
      .DATA_W (DATA_W)
   ) u_logic (
      .a_i   (opa_i),
      .b_i   (src_b),
      .fn_i  (ctrl.lfn),
      .res_o (logic_res)
   );

   always_comb begin
      case (ctrl.sel)
         SEL_ARITH: result_o = sum;
         SEL_LOGIC: result_o = logic_res;
         SEL_SLTS:  result_o = {{FLAG_PAD{1'b0}}, lt_s};
         SEL_SLTU:  result_o = {{FLAG_PAD{1'b0}}, lt_u};
         SEL_PASSB: result_o = src_b;
         default:   result_o = '0;
      endcase
   end

   assign ovf_o = ctrl.trap & raw_ovf;

endmodule

// File: rtl/int_alu_chk.sv
module int_alu_chk
   import int_alu_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int IMM_W  = 16
) (
   input logic [DATA_W-1:0] opa_i,
   input logic [DATA_W-1:0] opb_i,
   input logic [IMM_W-1:0]  imm_i,
   input logic [4:0]        op_i,
   input logic [DATA_W-1:0] result_o,
   input logic              ovf_o
);

   localparam int PAD_W = DATA_W - IMM_W;
   localparam int MSB   = DATA_W - 1;

   logic              known;
   logic [DATA_W-1:0] imm_s;
   logic [DATA_W-1:0] exp_addiu;

   assign known     = !$isunknown({opa_i, opb_i, imm_i, op_i});
   assign imm_s     = {{PAD_W{imm_i[IMM_W-1]}}, imm_i};
   assign exp_addiu = opa_i + imm_s;

   always_comb begin
      if (known) begin
         if (op_i == OP_ANDI)
            AST_ANDI_ZEXT: assert (result_o[MSB:IMM_W] == '0); // R1
         if (op_i == OP_ORI)
            AST_ORI_UPPER: assert (result_o[MSB:IMM_W] == opa_i[MSB:IMM_W]); // R8
         if (op_i == OP_ADDIU)
            AST_ADDIU_SEXT: assert (result_o == exp_addiu); // R2
         if (op_i != OP_ADD && op_i != OP_SUB && op_i != OP_ADDI)
            AST_NO_OVERFLOW: assert (!ovf_o); // R3
         if (op_i == OP_ADD)
            AST_ADD_OVF: assert (ovf_o == ((opa_i[MSB] == opb_i[MSB]) && (result_o[MSB] != opa_i[MSB]))); // R4
         if (op_i == OP_SUB)
            AST_SUB_OVF: assert (ovf_o == ((opa_i[MSB] != opb_i[MSB]) && (result_o[MSB] != opa_i[MSB]))); // R4
         if (op_i == OP_LUI)
            AST_LUI_FIELD: assert (result_o == {imm_i, {PAD_W{1'b0}}}); // R5
         if (op_i == OP_SLT)
            AST_SLT_SIGNED: assert (result_o == {{MSB{1'b0}}, ($signed(opa_i) < $signed(opb_i))}); // R6
         if (op_i == OP_SLTU || op_i == OP_SLTIU)
            AST_SLTU_BOOL: assert (result_o[MSB:1] == '0); // R7
         if (op_i > OP_LUI)
            AST_UNDEF_ZERO: assert (result_o == '0 && !ovf_o); // R11
      end
   end

endmodule

bind int_alu int_alu_chk #(
   .DATA_W (DATA_W),
   .IMM_W  (IMM_W)
) chk_i (
   .opa_i    (opa_i),
   .opb_i    (opb_i),
   .imm_i    (imm_i),
   .op_i     (op_i),
   .result_o (result_o),
   .ovf_o    (ovf_o)
);

// File: tb/int_alu_tb_top.sv
module int_alu_tb_top;

   logic        clk;
   logic        rst;
   logic [31:0] opa;
   logic [31:0] opb;
   logic [15:0] imm;
   logic [4:0]  op;
   logic [31:0] result;
   logic        ovf;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 0;

   initial clk = 1'b0;
   always #10 clk = ~clk;

   int_alu dut_i (
      .opa_i    (opa),
      .opb_i    (opb),
      .imm_i    (imm),
      .op_i     (op),
      .result_o (result),
      .ovf_o    (ovf)
   );

   task automatic chk(input string tag, input logic [31:0] got_r, input logic [31:0] exp_r,
                      input logic got_o, input logic exp_o);
      n_chk++;
      if (got_r !== exp_r || got_o !== exp_o) begin
         n_fail++;
         $display("FAIL %s: result=%h ovf=%b expected result=%h ovf=%b",
                  tag, got_r, got_o, exp_r, exp_o);
      end
   endtask

   task automatic drive(input logic [4:0] c, input logic [31:0] a, input logic [31:0] b,
                        input logic [15:0] i);
      @(negedge clk);
      op = c; opa = a; opb = b; imm = i;
      #2;
   endtask

   task automatic run(input string tag, input logic [4:0] c, input logic [31:0] a,
                      input logic [31:0] b, input logic [15:0] i,
                      input logic [31:0] er, input logic eo);
      drive(c, a, b, i);
      chk(tag, result, er, ovf, eo);
   endtask

   task automatic t_reset;
      @(negedge clk);
      chk("R9 idle add of zeros", result, 32'h0, ovf, 1'b0);
   endtask

   task automatic t_regops;
      run("R9 AND",  5'h04, 32'hF0F0F0F0, 32'hFF00FF00, 16'h0, 32'hF000F000, 1'b0);
      run("R9 OR",   5'h05, 32'hF0F0F0F0, 32'hFF00FF00, 16'h0, 32'hFFF0FFF0, 1'b0);
      run("R9 XOR",  5'h06, 32'hF0F0F0F0, 32'hFF00FF00, 16'h0, 32'h0FF00FF0, 1'b0);
      run("R9 NOR",  5'h07, 32'hF0F0F0F0, 32'hFF00FF00, 16'h0, 32'h000F000F, 1'b0);
      run("R9 ADDU", 5'h01, 32'h12345678, 32'h11111111, 16'h0, 32'h23456789, 1'b0);
      run("R9 SUBU", 5'h03, 32'h5, 32'h7, 16'h0, 32'hFFFFFFFE, 1'b0);
   endtask

   task automatic t_logic_imm;
      run("R1 ANDI zext", 5'h0C, 32'hFFFFFFFF, 32'h0, 16'h8001, 32'h00008001, 1'b0);
      run("R1 ORI zext",  5'h0D, 32'h0, 32'hFFFFFFFF, 16'hFFFF, 32'h0000FFFF, 1'b0);
      run("R1 XORI zext", 5'h0E, 32'hFFFF0000, 32'h0, 16'hFFFF, 32'hFFFFFFFF, 1'b0);
   endtask

   task automatic t_arith_imm;
      run("R2 ADDIU sext",     5'h0B, 32'h0, 32'h0, 16'hFFFF, 32'hFFFFFFFF, 1'b0);
      run("R2 ADDI negative",  5'h0A, 32'h5, 32'h0, 16'h8000, 32'hFFFF8005, 1'b0);
      run("R2 R4 ADDI wrap",   5'h0A, 32'h80000000, 32'h0, 16'hFFFF, 32'h7FFFFFFF, 1'b1);
      run("R4 ADDI pos wrap",  5'h0A, 32'h7FFFFFFF, 32'h0, 16'h0001, 32'h80000000, 1'b1);
      run("R3 ADDIU no trap",  5'h0B, 32'h7FFFFFFF, 32'h0, 16'h0001, 32'h80000000, 1'b0);
   endtask

   task automatic t_overflow;
      run("R4 ADD wrap",     5'h00, 32'h7FFFFFFF, 32'h1, 16'h0, 32'h80000000, 1'b1);
      run("R3 ADDU no trap", 5'h01, 32'h7FFFFFFF, 32'h1, 16'h0, 32'h80000000, 1'b0);
      run("R4 SUB wrap",     5'h02, 32'h80000000, 32'h1, 16'h0, 32'h7FFFFFFF, 1'b1);
      run("R3 SUBU no trap", 5'h03, 32'h80000000, 32'h1, 16'h0, 32'h7FFFFFFF, 1'b0);
      run("R4 ADD carry only", 5'h00, 32'hFFFFFFFF, 32'h1, 16'h0, 32'h0, 1'b0);
      run("R4 SUB from zero",  5'h02, 32'h0, 32'h80000000, 16'h0, 32'h80000000, 1'b1);
      run("R3 NOR no trap",  5'h07, 32'h7FFFFFFF, 32'h7FFFFFFF, 16'h0, 32'h80000000, 1'b0);
      // Mixed patterns against a 33-bit reference
      begin
         logic [31:0] a = 32'h1234ABCD;
         logic [31:0] b = 32'h9E3779B9;
         for (int k = 0; k < 48; k++) begin
            logic [32:0] s;
            logic [32:0] d;
            a = a * 32'd1664525 + 32'd1013904223;
            b = b * 32'd22695477 + 32'd1;
            s = {a[31], a} + {b[31], b};
            d = {a[31], a} - {b[31], b};
            run("R4 ADD pattern", 5'h00, a, b, 16'h0, s[31:0], s[32] != s[31]);
            run("R4 SUB pattern", 5'h02, a, b, 16'h0, d[31:0], d[32] != d[31]);
         end
      end
   endtask

   task automatic t_lui;
      run("R5 LUI",        5'h11, 32'hFFFFFFFF, 32'hFFFFFFFF, 16'h1234, 32'h12340000, 1'b0);
      run("R5 LUI top bit", 5'h11, 32'h0, 32'h0, 16'h8000, 32'h80000000, 1'b0);
   endtask

   task automatic t_const;
      logic [31:0] hi;
      drive(5'h11, 32'h0, 32'h0, 16'hAABB);
      hi = result;
      chk("R8 LUI half", hi, 32'hAABB0000, ovf, 1'b0);
      run("R8 ORI low half", 5'h0D, hi, 32'h0, 16'hCCDD, 32'hAABBCCDD, 1'b0);
   endtask

   task automatic t_slt;
      run("R6 SLT wrap neg",  5'h08, 32'h80000000, 32'h1, 16'h0, 32'h1, 1'b0);
      run("R6 SLT wrap pos",  5'h08, 32'h7FFFFFFF, 32'hFFFFFFFF, 16'h0, 32'h0, 1'b0);
      run("R6 SLT minus one", 5'h08, 32'hFFFFFFFF, 32'h0, 16'h0, 32'h1, 1'b0);
      run("R6 SLT equal",     5'h08, 32'h5, 32'h5, 16'h0, 32'h0, 1'b0);
      run("R6 SLTI vs zero",  5'h0F, 32'hFFFFFFFF, 32'h0, 16'h0000, 32'h1, 1'b0);
      run("R6 SLTI vs -1",    5'h0F, 32'h0, 32'h0, 16'hFFFF, 32'h0, 1'b0);
   endtask

   task automatic t_sltu;
      run("R7 SLTU big",      5'h09, 32'hFFFFFFFF, 32'h0, 16'h0, 32'h0, 1'b0);
      run("R7 SLTU small",    5'h09, 32'h0, 32'hFFFFFFFF, 16'h0, 32'h1, 1'b0);
      run("R7 SLTIU sext",    5'h10, 32'h0, 32'h0, 16'hFFFF, 32'h1, 1'b0);
      run("R7 SLTIU near",    5'h10, 32'hFFFFFFFE, 32'h0, 16'hFFFF, 32'h1, 1'b0);
      run("R7 SLTIU equal",   5'h10, 32'hFFFFFFFF, 32'h0, 16'hFFFF, 32'h0, 1'b0);
   endtask

   task automatic t_undef;
      run("R11 code 12", 5'h12, 32'h7FFFFFFF, 32'h1, 16'hFFFF, 32'h0, 1'b0);
      run("R11 code 1F", 5'h1F, 32'hFFFFFFFF, 32'hFFFFFFFF, 16'h1234, 32'h0, 1'b0);
   endtask

   task automatic t_same_cycle;
      @(negedge clk);
      op = 5'h00; opa = 32'h10; opb = 32'h20; imm = 16'h0;
      #1;
      chk("R10 first value", result, 32'h30, ovf, 1'b0);
      op = 5'h02; opa = 32'h10; opb = 32'h20;
      #1;
      chk("R10 same cycle change", result, 32'hFFFFFFF0, ovf, 1'b0);
   endtask

   task automatic finish_run;
      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      rst = 1'b1;
      op = 5'h00; opa = 32'h0; opb = 32'h0; imm = 16'h0;
      repeat (3) @(posedge clk);
      rst = 1'b0;
      t_reset();
      t_regops();
      t_logic_imm();
      t_arith_imm();
      t_overflow();
      t_lui();
      t_const();
      t_slt();
      t_sltu();
      t_undef();
      t_same_cycle();
      repeat (2) @(posedge clk);
      finish_run();
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=complete");
      finish_run();
   end

endmodule